// File: doc/BRIEF.md
# Instruction Cache ECC Recovery Sequencer

This block watches the ECC check results of an instruction cache lookup and handles any error by recovery, not by a trap. Instruction cache lines are never dirty, so a corrupted line can be dropped and fetched again. When a tag-array error or a data-array error is reported for a lookup, the block captures the set and way of that lookup. It issues a one-cycle flush of the affected valid bits, then a one-cycle miss request for the same set. It then waits for the refill response.

A tag error makes the hit way untrustworthy, so the flush clears the set in every way. A data error clears only the hit way. An access fault goes to the fetch unit only when the refill response comes back marked corrupt. The ECC errors alone never raise one. While a recovery is in progress, a stall output holds the lookup pipeline. Lookups and error reports that arrive during that time are dropped.

Top module: `icache_ecc_recovery`

## Requirements
- R1: A tag error (`metaErr`=1), sampled with ECC enabled and the block idle, produces one cycle of `flushValid` with `flushWayMask` all ones. This happens in the cycle after the flags are sampled.
- R2: A data error alone (`dataErr`=1, `metaErr`=0) produces a flush whose `flushWayMask` has only bit `lkpWay` set.
- R3: When both error flags are set in the same cycle, the tag action wins and the mask is all ones.
- R4: The error flags belong to the lookup accepted two clock edges before them. The flush and miss request carry that lookup's set index.
- R5: `missReqValid` pulses for exactly one cycle, in the cycle right after the flush. It never overlaps the flush, and `missSet` is the flushed set.
- R6: After the miss request the block waits for `refillValid`. In the cycle after the refill is accepted, `faultValid` equals the `refillCorrupt` sampled with it, and the block then returns to idle.
- R7: A recovery whose refill is not corrupt never raises `faultValid`, whichever array reported the error.
- R8: With `eccEn` low, error flags are ignored: no flush, no miss request, no stall.
- R9: `stall` is high from the flush cycle through the fault-report cycle. Lookups issued and error flags raised while `stall` is high start no new recovery.
- R10: A refill response that arrives while the block is idle produces no fault and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| eccEn | input | 1 | ECC checking enable |
| lkpValid | input | 1 | Lookup request accepted this cycle |
| lkpSet | input | SET_W | Set index of the lookup |
| lkpWay | input | WAY_W | Hit way of the lookup |
| metaErr | input | 1 | Tag-array ECC error, two cycles after lookup |
| dataErr | input | 1 | Data-array ECC error, two cycles after lookup |
| refillValid | input | 1 | Refill response from the next level |
| refillCorrupt | input | 1 | Refill response marked corrupt |
| flushValid | output | 1 | Valid-bit flush command |
| flushSet | output | SET_W | Set to flush |
| flushWayMask | output | NUM_WAYS | Ways to flush (bit n = way n) |
| missReqValid | output | 1 | Re-fetch request to the refill unit |
| missSet | output | SET_W | Set of the re-fetch request |
| faultValid | output | 1 | Access fault to the fetch unit |
| stall | output | 1 | Hold the lookup pipeline |

## Verification
Two things can coincide in one cycle: a tag error and a data error for the same lookup. The bench produces this by raising both flags in the sampling cycle for every set and way of a small configuration. It expects the all-ones mask, never the one-hot mask of the hit way. A second kind of collision also gets a test: a new lookup and its error flags arrive while an earlier recovery is still waiting for its refill. The bench checks that this produces no further flush once the first recovery ends.

// File: rtl/ecc_rcv_pkg.sv
package ecc_rcv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_MISS,
    ST_WAIT,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic capture;       // latch set and way mask of the failing lookup
    logic latchCorrupt;  // record refill corrupt flag
    logic reportFault;   // fault report cycle
    logic pipeHold;      // block new lookups from entering the delay line
  } seqStrobe_t;
endpackage

// File: rtl/ecc_rcv_ctrl.sv
module ecc_rcv_ctrl
  import ecc_rcv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       eccEn,
  input  logic       stg2Valid,
  input  logic       metaErr,
  input  logic       dataErr,
  input  logic       refillValid,
  output seqStrobe_t strobe,
  output logic       flushValid,
  output logic       missReqValid,
  output logic       stall
);
  seqState_t state, stateNext;
  logic      errHit;

  assign errHit = (state == ST_IDLE) && stg2Valid && eccEn && (metaErr || dataErr);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (errHit) stateNext = ST_FLUSH;
      ST_FLUSH: stateNext = ST_MISS;
      ST_MISS:  stateNext = ST_WAIT;
      ST_WAIT:  if (refillValid) stateNext = ST_DONE;
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.capture      = errHit;
    strobe.latchCorrupt = (state == ST_WAIT) && refillValid;
    strobe.reportFault  = (state == ST_DONE);
    strobe.pipeHold     = (state != ST_IDLE);
  end

  assign flushValid   = (state == ST_FLUSH);
  assign missReqValid = (state == ST_MISS);
  assign stall        = (state != ST_IDLE);
endmodule

// File: rtl/ecc_rcv_dp.sv
module ecc_rcv_dp
  import ecc_rcv_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int SET_W    = 6,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic                lkpValid,
  input  logic [SET_W-1:0]    lkpSet,
  input  logic [WAY_W-1:0]    lkpWay,
  input  logic                metaErr,
  input  logic                refillCorrupt,
  output logic                stg2Valid,
  output logic [SET_W-1:0]    capSet,
  output logic [NUM_WAYS-1:0] capMask,
  output logic                faultValid
);
  logic               stg1Valid;
  logic [SET_W-1:0]   stg1Set, stg2Set;
  logic [WAY_W-1:0]   stg1Way, stg2Way;
  logic [NUM_WAYS-1:0] maskNext;
  logic               corruptReg;

  // two-stage delay line aligning lookup with its late ECC flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stg1Valid <= 1'b0;
      stg2Valid <= 1'b0;
      stg1Set   <= '0;
      stg2Set   <= '0;
      stg1Way   <= '0;
      stg2Way   <= '0;
    end else begin
      stg1Valid <= lkpValid && !strobe.pipeHold;
      stg2Valid <= stg1Valid && !strobe.pipeHold;
      stg1Set   <= lkpSet;
      stg2Set   <= stg1Set;
      stg1Way   <= lkpWay;
      stg2Way   <= stg1Way;
    end
  end

  // tag error: every way; data error: hit way only
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_mask
    assign maskNext[w] = metaErr || (stg2Way == WAY_W'(w));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capSet     <= '0;
      capMask    <= '0;
      corruptReg <= 1'b0;
    end else begin
      if (strobe.capture) begin
        capSet  <= stg2Set;
        capMask <= maskNext;
      end
      if (strobe.latchCorrupt) corruptReg <= refillCorrupt;
    end
  end

  assign faultValid = strobe.reportFault && corruptReg;
endmodule

// File: rtl/icache_ecc_recovery.sv
module icache_ecc_recovery
  import ecc_rcv_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int SET_W    = 6,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                eccEn,
  input  logic                lkpValid,
  input  logic [SET_W-1:0]    lkpSet,
  input  logic [WAY_W-1:0]    lkpWay,
  input  logic                metaErr,
  input  logic                dataErr,
  input  logic                refillValid,
  input  logic                refillCorrupt,
  output logic                flushValid,
  output logic [SET_W-1:0]    flushSet,
  output logic [NUM_WAYS-1:0] flushWayMask,
  output logic                missReqValid,
  output logic [SET_W-1:0]    missSet,
  output logic                faultValid,
  output logic                stall
);
  seqStrobe_t       strobe;
  logic             stg2Valid;
  logic [SET_W-1:0] capSet;

  ecc_rcv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .eccEn(eccEn), .stg2Valid(stg2Valid),
    .metaErr(metaErr), .dataErr(dataErr), .refillValid(refillValid),
    .strobe(strobe), .flushValid(flushValid), .missReqValid(missReqValid),
    .stall(stall)
  );

  ecc_rcv_dp #(.NUM_WAYS(NUM_WAYS), .SET_W(SET_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lkpValid(lkpValid),
    .lkpSet(lkpSet), .lkpWay(lkpWay), .metaErr(metaErr),
    .refillCorrupt(refillCorrupt), .stg2Valid(stg2Valid),
    .capSet(capSet), .capMask(flushWayMask), .faultValid(faultValid)
  );

  assign flushSet = capSet;
  assign missSet  = capSet;
endmodule

// File: rtl/icache_ecc_recovery_chk.sv
module icache_ecc_recovery_chk #(
  parameter int NUM_WAYS = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                eccEn,
  input logic                metaErr,
  input logic                dataErr,
  input logic                refillValid,
  input logic                refillCorrupt,
  input logic                stg2Valid,
  input logic                flushValid,
  input logic [NUM_WAYS-1:0] flushWayMask,
  input logic                missReqValid,
  input logic                faultValid,
  input logic                stall
);
  a_r1_meta_all_ways: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && stg2Valid && eccEn && metaErr) |=> (flushValid && (&flushWayMask)));

  a_r2_data_one_way: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && stg2Valid && eccEn && dataErr && !metaErr) |=>
      (flushValid && $countones(flushWayMask) == 1));

  a_r5_miss_after_flush: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |=> (missReqValid && !flushValid));

  a_r5_miss_has_flush: assert property (@(posedge clk) disable iff (!rstN)
    missReqValid |-> $past(flushValid));

  a_r6_fault_from_corrupt: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> $past(refillValid && refillCorrupt));

  a_r8_disabled_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && !eccEn) |=> !flushValid);

  a_r9_stall_covers: assert property (@(posedge clk) disable iff (!rstN)
    (flushValid || missReqValid || faultValid) |-> stall);

  a_r10_idle_refill: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && refillValid) |=> !faultValid);
endmodule

bind icache_ecc_recovery icache_ecc_recovery_chk #(.NUM_WAYS(NUM_WAYS)) u_chk (
  .clk(clk), .rstN(rstN), .eccEn(eccEn), .metaErr(metaErr), .dataErr(dataErr),
  .refillValid(refillValid), .refillCorrupt(refillCorrupt),
  .stg2Valid(stg2Valid), .flushValid(flushValid), .flushWayMask(flushWayMask),
  .missReqValid(missReqValid), .faultValid(faultValid), .stall(stall)
);

// File: tb/sim_icache_ecc_recovery.sv
`timescale 1ns/1ps
module sim_icache_ecc_recovery;
  localparam int NW = 4;
  localparam int SW = 3;
  localparam int WW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eccEn = 1'b0, lkpValid = 1'b0, metaErr = 1'b0, dataErr = 1'b0;
  logic refillValid = 1'b0, refillCorrupt = 1'b0;
  logic [SW-1:0] lkpSet = '0;
  logic [WW-1:0] lkpWay = '0;
  logic flushValid, missReqValid, faultValid, stall;
  logic [SW-1:0] flushSet, missSet;
  logic [NW-1:0] flushWayMask;

  int checks = 0;
  int failures = 0;
  bit doneRun = 1'b0;

  always #2 clk = ~clk;

  icache_ecc_recovery #(.NUM_WAYS(NW), .SET_W(SW)) u0 (
    .clk(clk), .rstN(rstN), .eccEn(eccEn), .lkpValid(lkpValid), .lkpSet(lkpSet),
    .lkpWay(lkpWay), .metaErr(metaErr), .dataErr(dataErr),
    .refillValid(refillValid), .refillCorrupt(refillCorrupt),
    .flushValid(flushValid), .flushSet(flushSet), .flushWayMask(flushWayMask),
    .missReqValid(missReqValid), .missSet(missSet), .faultValid(faultValid),
    .stall(stall)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one lookup, flags two edges later, then optional recovery with refill
  task automatic runCase(input int s, input int w, input bit m, input bit d,
                         input bit en, input bit cor, input int gap);
    logic [NW-1:0] expMask;
    bit act;
    act = en && (m || d);
    expMask = m ? {NW{1'b1}} : (NW'(1) << w);
    @(negedge clk); lkpValid = 1'b1; lkpSet = SW'(s); lkpWay = WW'(w);
    @(negedge clk); lkpValid = 1'b0; lkpSet = ~SW'(s); lkpWay = ~WW'(w);
    @(negedge clk); metaErr = m; dataErr = d; eccEn = en;
    @(negedge clk); metaErr = 1'b0; dataErr = 1'b0;
    check(act ? "R1/R8 flush" : "R8 no flush", {31'd0, flushValid}, {31'd0, act});
    check("R8 stall", {31'd0, stall}, {31'd0, act});
    if (!act) return;
    if (m) check(d ? "R3 both mask" : "R1 meta mask", 32'(flushWayMask), 32'(expMask));
    else   check("R2 data mask", 32'(flushWayMask), 32'(expMask));
    check("R4 flush set", 32'(flushSet), 32'(s));
    @(negedge clk);
    check("R5 miss", {30'd0, flushValid, missReqValid}, 32'd1);
    check("R5 miss set", 32'(missSet), 32'(s));
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      check("R6 wait", {29'd0, missReqValid, faultValid, stall}, 32'd1);
    end
    @(negedge clk); refillValid = 1'b1; refillCorrupt = cor;
    @(negedge clk); refillValid = 1'b0; refillCorrupt = 1'b0;
    check(cor ? "R6 fault" : "R7 no fault", {31'd0, faultValid}, {31'd0, cor});
    check("R9 stall done", {31'd0, stall}, 32'd1);
    @(negedge clk);
    check("R6 idle", {30'd0, stall, faultValid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset", {28'd0, flushValid, missReqValid, faultValid, stall}, 32'd0);
    rstN = 1'b1;
    // sweep: set x way x error kind x enable x corrupt
    for (int s = 0; s < (1 << SW); s++)
      for (int w = 0; w < NW; w++)
        for (int k = 0; k < 4; k++)
          for (int e = 0; e < 2; e++)
            runCase(s, w, k[0], k[1], e[0], (s + w + k) % 2 == 1, (s + k) % 3);
    // R9: lookup + flags while busy start nothing
    @(negedge clk); eccEn = 1'b1;
    fork
      runCase(5, 2, 1'b0, 1'b1, 1'b1, 1'b0, 6);
      begin
        repeat (4) @(negedge clk);
        lkpValid = 1'b1; lkpSet = 3'd1; lkpWay = 2'd1;
        @(negedge clk); lkpValid = 1'b0;
        @(negedge clk); metaErr = 1'b1;
        @(negedge clk); metaErr = 1'b0;
      end
    join
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R9 busy ignored", {30'd0, flushValid, stall}, 32'd0);
    end
    // R10: stray refill while idle
    @(negedge clk); refillValid = 1'b1; refillCorrupt = 1'b1;
    @(negedge clk); refillValid = 1'b0; refillCorrupt = 1'b0;
    check("R10 idle refill", {30'd0, faultValid, stall}, 32'd0);
    doneRun = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (doneRun) break;
    end
    if (!doneRun) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule